// File: doc/BRIEF.md
# Receive Byte Queue with Data-Ready Event

This block is the receive-side holding queue of a serial port. A deserializer hands it one byte at a time through a strobe. The bytes wait in a small circular store that keeps a head index and an occupancy count. The oldest byte always appears on the data output. A bus read of the data register removes that byte, but only while reception is running. The block reports its remaining room so the sender can be throttled. It also emits a one-cycle data-ready event whenever it takes in a byte, and again after each removal that leaves bytes unread.

Reception is controlled by a two-state machine. `RXQ_STOPPED` is the reset state. The transition `go` (a start strobe without a stop strobe) moves it to `RXQ_RUNNING`. The transition `halt` (a stop strobe) moves it back to `RXQ_STOPPED`. In every other cycle the state holds (`stay`). While stopped, the advertised room is zero and reads leave the queue untouched. The queue contents are kept across a stop.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the queue is empty, reception is stopped, `head_byte` is 0x00, `free_slots` is 0 and `ready_evt` is low.
- R2: An accepted byte is stored at slot (head + count) modulo DEPTH, so bytes leave in arrival order.
- R3: A byte that arrives while the count equals DEPTH is dropped: it is not stored, the count stays at DEPTH, and no event is raised for it.
- R4: A read removes the head byte, advancing the head with wrap at DEPTH and decrementing the count, only when reception is running and the count is nonzero; any other read changes nothing.
- R5: `head_byte` always shows the slot at the head index, including the stale byte left there when the queue is empty.
- R6: `free_slots` equals DEPTH minus the count while running, and 0 while stopped.
- R7: Every accepted byte makes `ready_evt` high for the cycle after it is taken in.
- R8: A removal that leaves the count nonzero raises `ready_evt` in the next cycle. A removal that empties the queue, with no byte arriving, does not.
- R9: An accepted byte and a removal in the same cycle leave the count unchanged, and both head and tail advance.
- R10: `rx_start` moves `RXQ_STOPPED` to `RXQ_RUNNING`, and `rx_stop` moves to `RXQ_STOPPED`. When both strobes come together, stop wins. The new state governs reads and `free_slots` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_start | input | 1 | Strobe that starts reception |
| rx_stop | input | 1 | Strobe that stops reception |
| in_valid | input | 1 | Incoming byte strobe from the deserializer |
| in_byte | input | DW (8) | Incoming byte |
| rd_strobe | input | 1 | Bus read of the data register |
| head_byte | output | DW (8) | Byte at the head index |
| free_slots | output | $clog2(DEPTH+1) (3) | Advertised room for flow control |
| ready_evt | output | 1 | One-cycle data-ready event |

## Verification
A byte can arrive in the same cycle as a bus read. That one cycle then touches the stored slot, the head index, the count and the event together. The bench forces this coincidence in directed runs on a partly filled queue and on a full queue (where the arriving byte is dropped while the read still pops). It also lets the coincidence occur often under seeded random traffic. Each cycle, a bench model computes the expected head byte, room and event from the requirements, and the design's outputs are compared against it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [0:0] {
        RXQ_STOPPED = 1'b0,
        RXQ_RUNNING = 1'b1
    } rxq_state_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic run_o
);
    rxq_state_e state_q, state_d;

    // next-state: go / halt / stay
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXQ_STOPPED: if (start_i && !stop_i) state_d = RXQ_RUNNING;
            RXQ_RUNNING: if (stop_i)             state_d = RXQ_STOPPED;
            default:                             state_d = RXQ_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXQ_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RXQ_RUNNING: run_o = 1'b1;
            default:     run_o = 1'b0;
        endcase
    end

    // stop strobe always lands in STOPPED
    assert_stop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !run_o);
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 6,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [PW-1:0] widx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [PW-1:0] ridx_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot_q[i] <= '0;
            else if (we_i && widx_i == PW'(i))   slot_q[i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx_i == PW'(i)) rdata_o = slot_q[i];
        end
    end

    assert_widx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(widx_i) < DEPTH));
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
    parameter int DEPTH = 6,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          push_i,
    input  logic          rd_i,
    output logic          accept_o,
    output logic [PW-1:0] head_o,
    output logic [PW-1:0] tail_o,
    output logic [CW-1:0] count_o,
    output logic          evt_o
);
    logic [PW-1:0] head_q, head_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   tail_sum;
    logic          evt_q, evt_d;
    logic          full, empty, pop;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign accept_o = push_i && !full;
    assign pop      = rd_i && run_i && !empty;

    assign tail_sum = (CW+1)'(head_q) + (CW+1)'(cnt_q);
    always_comb begin
        if (tail_sum >= (CW+1)'(DEPTH)) tail_o = PW'(tail_sum - (CW+1)'(DEPTH));
        else                            tail_o = PW'(tail_sum);
    end

    always_comb begin
        head_d = head_q;
        if (pop) head_d = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
        unique case ({accept_o, pop})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
        evt_d = accept_o || (pop && cnt_d != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
            evt_q  <= 1'b0;
        end else begin
            head_q <= head_d;
            cnt_q  <= cnt_d;
            evt_q  <= evt_d;
        end
    end

    assign head_o  = head_q;
    assign count_o = cnt_q;
    assign evt_o   = evt_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !rd_i) |=> (cnt_q == CW'(DEPTH)));
    assert_read_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !run_i && !push_i) |=> ($stable(head_q) && $stable(cnt_q)));
    assert_drain_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && run_i && cnt_q == CW'(1) && !push_i) |=> !evt_q);
    assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && rd_i && run_i && !empty && !full) |=> $stable(cnt_q));
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
    parameter int DEPTH = 6,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_start,
    input  logic          rx_stop,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic          rd_strobe,
    output logic [DW-1:0] head_byte,
    output logic [CW-1:0] free_slots,
    output logic          ready_evt
);
    logic          run;
    logic          accept;
    logic [PW-1:0] head_idx, tail_idx;
    logic [CW-1:0] count;

    rxq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rx_start),
        .stop_i  (rx_stop),
        .run_o   (run)
    );

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .push_i   (in_valid),
        .rd_i     (rd_strobe),
        .accept_o (accept),
        .head_o   (head_idx),
        .tail_o   (tail_idx),
        .count_o  (count),
        .evt_o    (ready_evt)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (accept),
        .widx_i  (tail_idx),
        .wdata_i (in_byte),
        .ridx_i  (head_idx),
        .rdata_o (head_byte)
    );

    assign free_slots = run ? (CW'(DEPTH) - count) : '0;

    assert_room_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (free_slots == '0));
    assert_accept_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ready_evt);
endmodule

// File: tb/rxq_buffer_bench.sv
module rxq_buffer_bench;
    localparam int DEPTH = 6;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_start = 1'b0, rx_stop = 1'b0, in_valid = 1'b0, rd_strobe = 1'b0;
    logic [DW-1:0] in_byte = '0;
    logic [DW-1:0] head_byte;
    logic [CW-1:0] free_slots;
    logic          ready_evt;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [DW-1:0] m_mem [DEPTH];
    int  m_head = 0, m_cnt = 0;
    bit  m_run = 1'b0, m_evt = 1'b0;

    always #10 clk = ~clk;

    rxq_buffer #(.DEPTH(DEPTH), .DW(DW)) u_rxq_buffer (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_stop(rx_stop),
        .in_valid(in_valid), .in_byte(in_byte), .rd_strobe(rd_strobe),
        .head_byte(head_byte), .free_slots(free_slots), .ready_evt(ready_evt)
    );

    function automatic int exp_room();
        return m_run ? (DEPTH - m_cnt) : 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " head_byte (R5 R2)"}, int'(head_byte), int'(m_mem[m_head]));
        check({tag, " free_slots (R6)"}, int'(free_slots), exp_room());
        check({tag, " ready_evt (R7 R8)"}, int'(ready_evt), int'(m_evt));
    endtask

    // one cycle: check results of previous cycle, drive, advance model
    task automatic step(input string tag, input bit st, input bit sp,
                        input bit v, input logic [DW-1:0] b, input bit rd);
        bit acc, pop;
        @(negedge clk);
        check_all(tag);
        rx_start = st; rx_stop = sp; in_valid = v; in_byte = b; rd_strobe = rd;
        acc = v && (m_cnt < DEPTH);
        pop = rd && m_run && (m_cnt > 0);
        if (acc) m_mem[(m_head + m_cnt) % DEPTH] = b;
        if (pop) m_head = (m_head + 1) % DEPTH;
        m_cnt = m_cnt + int'(acc) - int'(pop);
        m_evt = acc || (pop && m_cnt != 0);
        if (sp)      m_run = 1'b0;
        else if (st) m_run = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [DW-1:0] r;
        seed = 32'h1d5eed;
        r = DW'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step("R1 reset", 0, 0, 0, 8'h00, 0);
        // R4 read while stopped: no pop; push while stopped still stored
        step("R4 push stopped", 0, 0, 1, 8'hA1, 0);
        step("R4 read stopped", 0, 0, 0, 8'h00, 1);
        step("R10 start", 1, 0, 0, 8'h00, 0);
        step("R10 observe run", 0, 0, 0, 8'h00, 0);
        // R3 fill to full and overflow
        for (int i = 0; i < DEPTH + 2; i++)
            step("R3 fill", 0, 0, 1, DW'(8'hB0 + i), 0);
        step("R3 full held", 0, 0, 0, 8'h00, 0);
        // R9 push and pop together on full queue (push dropped) and partial
        step("R9 full both", 0, 0, 1, 8'hCC, 1);
        step("R9 partial both", 0, 0, 1, 8'hCD, 1);
        // R8 drain to empty, then read empty (R5 stale head)
        for (int i = 0; i < DEPTH + 2; i++)
            step("R8 drain", 0, 0, 0, 8'h00, 1);
        step("R5 stale", 0, 0, 0, 8'h00, 0);
        // R10 start and stop together: stop wins
        step("R10 both", 1, 1, 0, 8'h00, 0);
        step("R10 stopped room", 0, 0, 1, 8'h5A, 1);
        step("R10 restart", 1, 0, 0, 8'h00, 0);
        // random traffic, including R9 coincidences and R2 wrap
        for (int i = 0; i < 3000; i++) begin
            int c;
            c = int'($urandom_range(99, 0));
            r = DW'($urandom);
            step("R2 random", (c < 3), (c >= 97), ($urandom_range(9, 0) < 5),
                 r, ($urandom_range(9, 0) < 4));
        end
        step("R2 final", 0, 0, 0, 8'h00, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule